// File: doc/BRIEF.md
# Capture-Mode Edge Timestamp Channel

This block is one 16-bit timer channel fixed in capture mode. Two input pins, A and B, pass through a two-flop synchronizer. Chosen edges on pin A copy the running count into two capture registers, RA and RB. Software reads the pair back to measure pulse width and period. The counter advances by one on each cycle in which the count-enable input is high, provided its clock is enabled and it is not halted. An external trigger edge on pin A or pin B, a software trigger, or a match against the limit register RC clears the count.

Software reaches the channel through a simple word-indexed register port. Writes take effect at the clock edge. Reads return data one edge later. The status register gathers the channel's events, and reading it clears the event bits. An interrupt output is raised while any unmasked event bit is set. The two captures always form ordered pairs: RA first, then RB. A capture that lands on data whose status has not been read yet is flagged as an overrun. Loading RB can optionally halt the counter or switch its clock off.

Top module: `tc_capture_channel`

## Requirements
- R1: After reset the count, RA, RB and the interrupt mask are 0, the clock is disabled, every status bit is 0 and `irq` is low.
- R2: Control register (index 0): writing bit0 enables the clock and writing bit1 disables it, and bit1 wins when both are written. While the clock is enabled and the counter is not halted, the count (index 4) rises by one on each cycle with `cnt_en` high; otherwise it holds.
- R3: Mode register (index 1) bits 17:16 select the pin-A edge that loads RA (0 none, 1 rising, 2 falling, 3 both). A load copies the count into RA (index 5) and sets status bit 5.
- R4: Mode bits 19:18 select the pin-A edge that loads RB (index 6), using the same encoding, and a load sets status bit 6. RB loads only when RA has loaded since the previous RB load, and RA loads only when that is not the case, so an RB edge seen with no pending RA changes nothing.
- R5: Status bit 1 (overrun) is set when RA loads while status bit 5 is still set, or when RB loads while status bit 6 is still set.
- R6: Status (index 8) bits 7:0 are event flags that a status read clears. A new event in the same cycle as the read wins over the clear. Bit 16 shows the clock is enabled, bit 17 shows the synchronized level of pin A and bit 18 shows the synchronized level of pin B.
- R7: When RB loads, mode bit 6 halts the counter until the next trigger, and mode bit 7 disables the clock.
- R8: Mode bits 9:8 select the external trigger edge (0 none, 1 rising, 2 falling, 3 both), and mode bit 10 picks pin A as its source when set, otherwise pin B. A trigger sets status bit 7, releases a halt, and makes the next counting cycle load 0 in place of an increment.
- R9: On a counting cycle where the count equals RC (index 7, reset value all ones), status bit 4 is set. With mode bit 14 set, that cycle loads 0 in place of an increment.
- R10: A counting cycle that increments the count from all ones wraps it to 0 and sets status bit 0.
- R11: Writing index 9 sets interrupt mask bits and writing index 10 clears them. Index 11 reads the mask back. `irq` is high exactly while a status bit in 7:0 has its mask bit set.
- R12: Control bit2 (software trigger) enables the clock and makes the next counting cycle load 0.
- R13: Mode bit 15 set makes the channel non-capture: no pin edge loads RA or RB or raises an external trigger. The mode register reads back only its defined bits (mask 0x000FC7C0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable qualifier, one step per high cycle |
| pin_a | input | 1 | Asynchronous capture/trigger pin A |
| pin_b | input | 1 | Asynchronous trigger pin B |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request |

## Verification
A pin change needs three clock edges before a capture or trigger reacts: two synchronizer stages, then the register load on the edge-detect strobe. The bench therefore waits four cycles after moving a pin before it reads anything back. Counter effects appear on the same edge as the counting cycle, and a trigger only marks the next counting cycle. For this reason the bench holds `cnt_en` low while pins move, which keeps every captured value exact, and then applies an exact number of counting cycles. Register reads return on the edge after the strobe and are sampled at the following falling edge. `irq` is checked at the falling edge after the write or status read that changes it.

// File: rtl/tc_cap_pkg.sv
package tc_cap_pkg;

    localparam int REG_W  = 32;
    localparam int FLAG_W = 8;

    // register word indices
    localparam logic [3:0] REG_CTRL  = 4'd0;
    localparam logic [3:0] REG_MODE  = 4'd1;
    localparam logic [3:0] REG_COUNT = 4'd4;
    localparam logic [3:0] REG_CAPA  = 4'd5;
    localparam logic [3:0] REG_CAPB  = 4'd6;
    localparam logic [3:0] REG_LIMIT = 4'd7;
    localparam logic [3:0] REG_STAT  = 4'd8;
    localparam logic [3:0] REG_IEN   = 4'd9;
    localparam logic [3:0] REG_IDIS  = 4'd10;
    localparam logic [3:0] REG_IMASK = 4'd11;

    localparam logic [REG_W-1:0] MODE_MASK = 32'h000F_C7C0;

    // event flag positions
    localparam int F_OVF  = 0;
    localparam int F_OVR  = 1;
    localparam int F_CMP  = 4;
    localparam int F_LDA  = 5;
    localparam int F_LDB  = 6;
    localparam int F_TRIG = 7;
    localparam int S_CLK  = 16;
    localparam int S_PINA = 17;
    localparam int S_PINB = 18;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic      wave;
        logic      limit_trig;
        logic      src_is_a;
        edge_sel_e trig_edge;
        logic      off_on_b;
        logic      halt_on_b;
        edge_sel_e a_edge;
        edge_sel_e b_edge;
    } mode_t;

    typedef struct packed {
        logic trig;
        logic load_b;
        logic load_a;
        logic cmp;
        logic overrun;
        logic wrap;
    } evt_t;

    function automatic mode_t decode_mode(input logic [REG_W-1:0] m);
        mode_t d;
        d.wave       = m[15];
        d.limit_trig = m[14];
        d.src_is_a   = m[10];
        d.trig_edge  = edge_sel_e'(m[9:8]);
        d.off_on_b   = m[7];
        d.halt_on_b  = m[6];
        d.a_edge     = edge_sel_e'(m[17:16]);
        d.b_edge     = edge_sel_e'(m[19:18]);
        return d;
    endfunction

    function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [FLAG_W-1:0] evt_to_flags(input evt_t e);
        logic [FLAG_W-1:0] f;
        f         = '0;
        f[F_OVF]  = e.wrap;
        f[F_OVR]  = e.overrun;
        f[F_CMP]  = e.cmp;
        f[F_LDA]  = e.load_a;
        f[F_LDB]  = e.load_b;
        f[F_TRIG] = e.trig;
        return f;
    endfunction

endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
    parameter int N_PINS = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins_i,
    output logic [N_PINS-1:0] level_o,
    output logic [N_PINS-1:0] rise_o,
    output logic [N_PINS-1:0] fall_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [DEPTH-1:0] shreg;

        always_ff @(posedge clk) begin
            if (rst) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[DEPTH-2:0], pins_i[i]};
            end
        end

        assign level_o[i] = shreg[STAGES-1];
        assign rise_o[i]  = shreg[STAGES-1] & ~shreg[STAGES];
        assign fall_o[i]  = ~shreg[STAGES-1] & shreg[STAGES];
    end
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             cmd_en_i,
    input  logic             cmd_dis_i,
    input  logic             cmd_sw_i,
    input  logic             ext_trig_i,
    input  logic             halt_req_i,
    input  logic             off_req_i,
    input  logic             limit_trig_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             clk_on_o,
    output logic             halted_o,
    output logic             pend_o,
    output logic             cmp_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             clk_on_q, halted_q, pend_q;
    logic             run, hit, trig_any;

    assign trig_any = cmd_sw_i | ext_trig_i;
    assign run      = tick_i & clk_on_q & ~halted_q;
    assign hit      = (cnt_q == limit_i);

    always_comb begin
        cnt_d  = cnt_q;
        cmp_o  = 1'b0;
        wrap_o = 1'b0;
        if (run) begin
            if (pend_q) begin
                cnt_d = '0;
            end else begin
                cmp_o = hit;
                if (hit && limit_trig_i) begin
                    cnt_d = '0;
                end else begin
                    cnt_d  = cnt_q + 1'b1;
                    wrap_o = (cnt_q == ALL_ONES);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            clk_on_q <= 1'b0;
            halted_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cmd_dis_i || off_req_i) begin
                clk_on_q <= 1'b0;
            end else if (cmd_en_i || cmd_sw_i) begin
                clk_on_q <= 1'b1;
            end
            if (trig_any) begin
                halted_q <= 1'b0;
            end else if (halt_req_i) begin
                halted_q <= 1'b1;
            end
            if (trig_any) begin
                pend_q <= 1'b1;
            end else if (run) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign clk_on_o = clk_on_q;
    assign halted_o = halted_q;
    assign pend_o   = pend_q;
endmodule

// File: rtl/tc_capture_unit.sv
module tc_capture_unit
    import tc_cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  edge_sel_e        a_sel_i,
    input  edge_sel_e        b_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             flag_a_i,
    input  logic             flag_b_i,
    output logic [CNT_W-1:0] ra_o,
    output logic [CNT_W-1:0] rb_o,
    output logic             load_a_o,
    output logic             load_b_o,
    output logic             overrun_o
);
    logic [CNT_W-1:0] ra_q, rb_q;
    logic             want_b_q;
    logic             hit_a, hit_b;

    assign hit_a     = active_i & edge_hit(a_sel_i, rise_i, fall_i);
    assign hit_b     = active_i & edge_hit(b_sel_i, rise_i, fall_i);
    assign load_a_o  = hit_a & ~want_b_q;
    assign load_b_o  = hit_b & want_b_q;
    assign overrun_o = (load_a_o & flag_a_i) | (load_b_o & flag_b_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q     <= '0;
            rb_q     <= '0;
            want_b_q <= 1'b0;
        end else begin
            if (load_a_o) begin
                ra_q     <= cnt_i;
                want_b_q <= 1'b1;
            end else if (load_b_o) begin
                rb_q     <= cnt_i;
                want_b_q <= 1'b0;
            end
        end
    end

    assign ra_o = ra_q;
    assign rb_o = rb_q;
endmodule

// File: rtl/tc_host_regs.sv
module tc_host_regs
    import tc_cap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  evt_t              evt_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  ra_i,
    input  logic [CNT_W-1:0]  rb_i,
    input  logic              clk_on_i,
    input  logic [1:0]        pin_lvl_i,
    output logic [REG_W-1:0]  mode_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              cmd_en_o,
    output logic              cmd_dis_o,
    output logic              cmd_sw_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] imask_o,
    output logic              irq_o
);
    logic [REG_W-1:0]  mode_q, rdata_q, stat_word;
    logic [CNT_W-1:0]  limit_q;
    logic [FLAG_W-1:0] flags_q, imask_q, set_vec;
    logic              wr_ctrl, rd_stat;

    assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
    assign rd_stat   = bus_rd && (bus_addr == REG_STAT);
    assign cmd_en_o  = wr_ctrl & bus_wdata[0];
    assign cmd_dis_o = wr_ctrl & bus_wdata[1];
    assign cmd_sw_o  = wr_ctrl & bus_wdata[2];
    assign set_vec   = evt_to_flags(evt_i);

    always_comb begin
        stat_word              = '0;
        stat_word[FLAG_W-1:0]  = flags_q;
        stat_word[S_CLK]       = clk_on_i;
        stat_word[S_PINA]      = pin_lvl_i[0];
        stat_word[S_PINB]      = pin_lvl_i[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            limit_q <= '1;
            flags_q <= '0;
            imask_q <= '0;
            rdata_q <= '0;
        end else begin
            flags_q <= (rd_stat ? '0 : flags_q) | set_vec;
            if (bus_wr) begin
                case (bus_addr)
                    REG_MODE:  mode_q  <= bus_wdata & MODE_MASK;
                    REG_LIMIT: limit_q <= bus_wdata[CNT_W-1:0];
                    REG_IEN:   imask_q <= imask_q | bus_wdata[FLAG_W-1:0];
                    REG_IDIS:  imask_q <= imask_q & ~bus_wdata[FLAG_W-1:0];
                    default:   ;
                endcase
            end
            if (bus_rd) begin
                case (bus_addr)
                    REG_MODE:  rdata_q <= mode_q;
                    REG_COUNT: rdata_q <= REG_W'(cnt_i);
                    REG_CAPA:  rdata_q <= REG_W'(ra_i);
                    REG_CAPB:  rdata_q <= REG_W'(rb_i);
                    REG_LIMIT: rdata_q <= REG_W'(limit_q);
                    REG_STAT:  rdata_q <= stat_word;
                    REG_IMASK: rdata_q <= REG_W'(imask_q);
                    default:   rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign mode_o    = mode_q;
    assign limit_o   = limit_q;
    assign flags_o   = flags_q;
    assign imask_o   = imask_q;
    assign irq_o     = |(flags_q & imask_q);
endmodule

// File: rtl/tc_capture_channel.sv
module tc_capture_channel
    import tc_cap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [1:0]        pin_lvl, pin_rise, pin_fall;
    logic [REG_W-1:0]  mode_raw;
    mode_t             mode;
    logic              capture_on, src_rise, src_fall, ext_trig;
    logic [CNT_W-1:0]  cnt_q, limit_q, ra_q, rb_q;
    logic              clk_on, halted, trig_pend, cmp_evt, wrap_evt;
    logic              ld_a, ld_b, ovr_evt;
    logic              cmd_en, cmd_dis, cmd_sw;
    logic [FLAG_W-1:0] flags, imask;
    evt_t              evt;

    tc_pin_sync #(.N_PINS(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pins_i  ({pin_b, pin_a}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign mode       = decode_mode(mode_raw);
    assign capture_on = ~mode.wave;
    assign src_rise   = mode.src_is_a ? pin_rise[0] : pin_rise[1];
    assign src_fall   = mode.src_is_a ? pin_fall[0] : pin_fall[1];
    assign ext_trig   = capture_on & edge_hit(mode.trig_edge, src_rise, src_fall);

    tc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (cnt_en),
        .cmd_en_i     (cmd_en),
        .cmd_dis_i    (cmd_dis),
        .cmd_sw_i     (cmd_sw),
        .ext_trig_i   (ext_trig),
        .halt_req_i   (ld_b & mode.halt_on_b),
        .off_req_i    (ld_b & mode.off_on_b),
        .limit_trig_i (mode.limit_trig),
        .limit_i      (limit_q),
        .cnt_o        (cnt_q),
        .clk_on_o     (clk_on),
        .halted_o     (halted),
        .pend_o       (trig_pend),
        .cmp_o        (cmp_evt),
        .wrap_o       (wrap_evt)
    );

    tc_capture_unit #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .active_i  (capture_on),
        .rise_i    (pin_rise[0]),
        .fall_i    (pin_fall[0]),
        .a_sel_i   (mode.a_edge),
        .b_sel_i   (mode.b_edge),
        .cnt_i     (cnt_q),
        .flag_a_i  (flags[F_LDA]),
        .flag_b_i  (flags[F_LDB]),
        .ra_o      (ra_q),
        .rb_o      (rb_q),
        .load_a_o  (ld_a),
        .load_b_o  (ld_b),
        .overrun_o (ovr_evt)
    );

    always_comb begin
        evt.trig    = ext_trig;
        evt.load_b  = ld_b;
        evt.load_a  = ld_a;
        evt.cmp     = cmp_evt;
        evt.overrun = ovr_evt;
        evt.wrap    = wrap_evt;
    end

    tc_host_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt),
        .cnt_i     (cnt_q),
        .ra_i      (ra_q),
        .rb_i      (rb_q),
        .clk_on_i  (clk_on),
        .pin_lvl_i (pin_lvl),
        .mode_o    (mode_raw),
        .limit_o   (limit_q),
        .cmd_en_o  (cmd_en),
        .cmd_dis_o (cmd_dis),
        .cmd_sw_o  (cmd_sw),
        .flags_o   (flags),
        .imask_o   (imask),
        .irq_o     (irq)
    );
endmodule

// File: rtl/tc_capture_checker.sv
module tc_capture_checker #(
    parameter int CNT_W  = 16,
    parameter int FLAG_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  limit_q,
    input logic              clk_on,
    input logic              halted,
    input logic              trig_pend,
    input logic              limit_trig,
    input logic              ld_a,
    input logic              ld_b,
    input logic              halt_on_b,
    input logic              off_on_b,
    input logic [FLAG_W-1:0] flags
);
    logic counting;
    assign counting = cnt_en && clk_on && !halted && !trig_pend
                      && !(limit_trig && cnt_q == limit_q);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && flags == '0 && !clk_on));

    // R2
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(cnt_q));

    // R2
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        counting |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R3
    a_r3_load_flag: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> flags[5]);

    // R4
    a_r4_load_flag: assert property (@(posedge clk) disable iff (rst)
        ld_b |=> flags[6]);

    // R5
    a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
        (ld_a && flags[5]) |=> flags[1]);

    // R7
    a_r7_halt: assert property (@(posedge clk) disable iff (rst)
        (ld_b && halt_on_b) |=> halted);

    // R7
    a_r7_clock_off: assert property (@(posedge clk) disable iff (rst)
        (ld_b && off_on_b) |=> !clk_on);

    // R10
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (counting && cnt_q == '1) |=> (flags[0] && cnt_q == '0));
endmodule

bind tc_capture_channel tc_capture_checker #(.CNT_W(CNT_W), .FLAG_W(tc_cap_pkg::FLAG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .cnt_q      (cnt_q),
    .limit_q    (limit_q),
    .clk_on     (clk_on),
    .halted     (halted),
    .trig_pend  (trig_pend),
    .limit_trig (mode.limit_trig),
    .ld_a       (ld_a),
    .ld_b       (ld_b),
    .halt_on_b  (mode.halt_on_b),
    .off_on_b   (mode.off_on_b),
    .flags      (flags)
);

// File: tb/tb_tc_capture_channel.sv
`timescale 1ns/1ps
module tb_tc_capture_channel;
    localparam int A_CTRL = 0, A_MODE = 1, A_CNT = 4, A_RA = 5, A_RB = 6;
    localparam int A_RC = 7, A_STAT = 8, A_IEN = 9, A_IDIS = 10, A_IMSK = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0, pin_a = 1'b0, pin_b = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tc_capture_channel dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .pin_a(pin_a), .pin_b(pin_b),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(addr);
        @(posedge clk);
        @(negedge clk);
        data = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic set_a(input logic v);
        @(negedge clk);
        pin_a = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_b(input logic v);
        @(negedge clk);
        pin_b = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CNT, d);  check("R1 count", d, 32'h0);
        rd(A_STAT, d); check("R1 status", d, 32'h0);
        rd(A_RA, d);   check("R1 RA", d, 32'h0);
        rd(A_IMSK, d); check("R1 mask", d, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(A_CTRL, 32'h1);
        tick(10);
        rd(A_CNT, d);  check("R2 count after 10", d, 32'd10);
        rd(A_STAT, d); check("R2 clock on", d, 32'h0001_0000);
        wr(A_CTRL, 32'h3);
        tick(5);
        rd(A_CNT, d);  check("R2 hold when disabled", d, 32'd10);
        rd(A_STAT, d); check("R2 disable wins", d, 32'h0);
        wr(A_CTRL, 32'h4);
        rd(A_STAT, d); check("R12 sw trigger enables", d, 32'h0001_0000);
        tick(1);
        rd(A_CNT, d);  check("R12 sw trigger zero", d, 32'd0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        wr(A_MODE, 32'h0009_0000);
        tick(7);
        set_a(1'b1);
        rd(A_RA, d);   check("R3 RA value", d, 32'd7);
        rd(A_STAT, d); check("R3 RA flag", d, 32'h0003_0020);
        tick(5);
        set_a(1'b0);
        rd(A_RB, d);   check("R4 RB value", d, 32'd12);
        rd(A_STAT, d); check("R6 status cleared, RB flag", d, 32'h0001_0040);
        wr(A_MODE, 32'h0008_0000);
        set_a(1'b1);
        set_a(1'b0);
        rd(A_STAT, d); check("R4 no RB without RA", d, 32'h0001_0000);
        rd(A_RB, d);   check("R4 RB unchanged", d, 32'd12);
        wr(A_MODE, 32'h0009_0000);
        tick(3);
        set_a(1'b1);
        set_a(1'b0);
        tick(1);
        set_a(1'b1);
        rd(A_RA, d);   check("R5 RA reload", d, 32'd16);
        rd(A_STAT, d); check("R5 overrun", d, 32'h0003_0062);
        rd(A_STAT, d); check("R6 read clears", d, 32'h0003_0000);
    endtask

    task automatic t_stop_trig();
        logic [31:0] d;
        wr(A_MODE, 32'h0008_0040);
        tick(2);
        set_a(1'b0);
        rd(A_RB, d);   check("R7 RB at halt", d, 32'd18);
        tick(5);
        rd(A_CNT, d);  check("R7 halted", d, 32'd18);
        rd(A_STAT, d);
        wr(A_MODE, 32'h0000_0100);
        set_b(1'b1);
        rd(A_STAT, d); check("R8 trigger flag B", d, 32'h0005_0080);
        tick(1);
        rd(A_CNT, d);  check("R8 trigger zero", d, 32'd0);
        tick(3);
        rd(A_CNT, d);  check("R8 runs after trigger", d, 32'd3);
        wr(A_MODE, 32'h0009_0080);
        set_a(1'b1);
        tick(2);
        set_a(1'b0);
        rd(A_STAT, d); check("R7 clock off on RB", d, 32'h0004_0060);
        tick(4);
        rd(A_CNT, d);  check("R7 count frozen", d, 32'd5);
        wr(A_MODE, 32'h0000_0600);
        wr(A_CTRL, 32'h1);
        set_b(1'b0);
        set_b(1'b1);
        rd(A_STAT, d); check("R8 pin B ignored when source A", d, 32'h0005_0000);
        set_a(1'b1);
        set_a(1'b0);
        rd(A_STAT, d); check("R8 falling trigger on A", d, 32'h0005_0080);
        tick(1);
        rd(A_CNT, d);  check("R8 A trigger zero", d, 32'd0);
    endtask

    task automatic t_compare();
        logic [31:0] d;
        wr(A_RC, 32'd4);
        wr(A_MODE, 32'h0000_4000);
        wr(A_CTRL, 32'h5);
        tick(1);
        rd(A_STAT, d);
        tick(5);
        rd(A_CNT, d);  check("R9 limit reset", d, 32'd0);
        rd(A_STAT, d); check("R9 compare flag", d & 32'h10, 32'h10);
        tick(2);
        rd(A_CNT, d);  check("R9 restart", d, 32'd2);
        wr(A_MODE, 32'h0);
        wr(A_CTRL, 32'h4);
        tick(1);
        rd(A_STAT, d);
        tick(3);
        rd(A_STAT, d); check("R9 no flag before match", d & 32'h10, 32'h0);
        tick(3);
        rd(A_CNT, d);  check("R9 passes limit", d, 32'd6);
        rd(A_STAT, d); check("R9 flag on pass", d & 32'h10, 32'h10);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(A_RC, 32'hFFFF);
        wr(A_CTRL, 32'h4);
        tick(1);
        rd(A_STAT, d);
        tick(65535);
        rd(A_STAT, d); check("R10 no wrap yet", d & 32'h1, 32'h0);
        tick(1);
        rd(A_CNT, d);  check("R10 wrapped", d, 32'd0);
        rd(A_STAT, d); check("R10 wrap flag", d & 32'h1, 32'h1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_IEN, 32'h10);
        rd(A_IMSK, d); check("R11 mask set", d, 32'h10);
        check("R11 irq idle", {31'b0, irq}, 32'h0);
        wr(A_RC, 32'd2);
        wr(A_CTRL, 32'h4);
        tick(1);
        tick(3);
        check("R11 irq raised", {31'b0, irq}, 32'h1);
        rd(A_STAT, d);
        check("R11 irq cleared by read", {31'b0, irq}, 32'h0);
        wr(A_IDIS, 32'h10);
        rd(A_IMSK, d); check("R11 mask clear", d, 32'h0);
    endtask

    task automatic t_wave();
        logic [31:0] d;
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, d); check("R13 mode readback", d, 32'h000F_C7C0);
        wr(A_MODE, 32'h0001_8100);
        rd(A_STAT, d);
        set_a(1'b1);
        set_b(1'b0);
        set_b(1'b1);
        rd(A_STAT, d); check("R13 no load or trigger", d & 32'hFF, 32'h0);
        rd(A_RA, d);   check("R13 RA unchanged", d, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_capture();
        t_stop_trig();
        t_compare();
        t_wrap();
        t_irq();
        t_wave();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule